// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block sequences temperature conversions inside a digital sensor. It has two operating modes, selected by a mode bit. In continuous mode it starts a new conversion each time the previous one completes. In shutdown mode it stays idle until software writes 1 to the one-shot bit. That write launches exactly one conversion, and the block then falls back to idle without further action.

The one-shot bit also works as a status bit when read. It reads 0 while a conversion is in progress. After a conversion has completed, it reads 1.

A built-in cycle counter models the conversion time. Its length is a parameter, so that a testbench can shorten it. Each completion loads the temperature sample into the result register and pulses a result-valid strobe for one cycle. The result path has no ready signal: the register accepts every completion, so no back-pressure exists. A constant read-only resolution field reports 12-bit results.

Top module: `oneshot_conv_ctrl`

## Requirements
- R1: During and after reset, with shutdown held at 1, the block is idle: `busy_o`=0, `conv_start_o`=0, `os_ready_o`=0, `result_valid_o`=0 and `temp_o`=0.
- R2: In shutdown mode, when idle, a write (`cfg_wr_i`=1) with `cfg_os_i`=1 at a clock edge gives `conv_start_o`=1 for exactly the next cycle. `busy_o` is then 1 for exactly CONV_CYCLES cycles.
- R3: `os_ready_o` reads 0 in every cycle in which `busy_o` is 1.
- R4: When a conversion completes in shutdown mode, the block returns to idle (`busy_o`=0) with no new start, and `os_ready_o` reads 1 from then until the next start.
- R5: A one-shot write is ignored when it arrives while a conversion is running or while in continuous mode. A write with `cfg_os_i`=0 is also ignored. None of these writes causes an extra start or an extra result.
- R6: With `shutdown_i`=0, conversions run back to back. `busy_o` stays 1 continuously, and `conv_start_o` pulses once every CONV_CYCLES cycles.
- R7: At each completion, `result_valid_o` is 1 for exactly one cycle. In that same cycle `temp_o` holds the value `temp_sample_i` had at the completing edge.
- R8: If `shutdown_i` is set during a continuous conversion, that conversion runs to completion and produces its result, and the block then stays idle.
- R9: `res_bits_o` always reads binary 11, which means 12-bit resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shutdown_i | input | 1 | Mode bit: 1 = shutdown (one-shot), 0 = continuous |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_os_i | input | 1 | One-shot bit value carried by the write |
| temp_sample_i | input | TEMP_W | Converter output, captured at completion |
| conv_start_o | output | 1 | One-cycle pulse at the first cycle of each conversion |
| busy_o | output | 1 | Conversion in progress |
| os_ready_o | output | 1 | Read value of the one-shot/ready bit |
| result_valid_o | output | 1 | One-cycle strobe: `temp_o` was just updated |
| temp_o | output | TEMP_W | Temperature result register |
| res_bits_o | output | 2 | Read-only resolution field (11) |

## Verification
The hardest case to reach is the change of mode in the middle of a conversion. Shutdown must be raised while a continuous conversion is in flight and away from its completion edge. The stimulus gets there by running three full back-to-back conversions, then setting shutdown in the first cycle of the fourth. It then checks that the fourth result still arrives and that no fifth start follows. A second hard case is a one-shot write that lands inside a running one-shot conversion. The bench injects that write halfway through and counts both the start pulses and the results.

// File: rtl/conv_pkg.sv
package conv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_e;

  localparam logic [1:0] RES_12BIT = 2'b11;
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CONV_CYCLES = 2600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic running_i,
  output logic done_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (running_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = running_i && (cnt_q == LAST);
endmodule

// File: rtl/os_sequencer.sv
module os_sequencer
  import conv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown_i,
  input  logic wr_i,
  input  logic wr_os_i,
  input  logic done_i,
  output logic start_now_o,
  output logic busy_o,
  output logic start_pulse_o,
  output logic ready_o
);
  conv_state_e state_q, state_d;
  logic        ready_q, start_q;
  logic        trigger;

  assign trigger = !shutdown_i || (wr_i && wr_os_i);

  always_comb begin
    state_d     = state_q;
    start_now_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trigger) begin
          state_d     = ST_CONV;
          start_now_o = 1'b1;
        end
      end
      ST_CONV: begin
        if (done_i) begin
          if (shutdown_i) state_d     = ST_IDLE;
          else            start_now_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_now_o;
      if (start_now_o) ready_q <= 1'b0;
      else if (done_i) ready_q <= 1'b1;
    end
  end

  assign busy_o        = (state_q == ST_CONV);
  assign start_pulse_o = start_q;
  assign ready_o       = ready_q;
endmodule

// File: rtl/temp_result.sv
module temp_result #(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [TEMP_W-1:0] sample_i,
  output logic              valid_o,
  output logic [TEMP_W-1:0] temp_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      temp_o  <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) temp_o <= sample_i;
    end
  end
endmodule

// File: rtl/oneshot_conv_ctrl.sv
module oneshot_conv_ctrl
  import conv_pkg::*;
#(
  parameter int CONV_CYCLES = 2600000,
  parameter int TEMP_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_os_i,
  input  logic [TEMP_W-1:0] temp_sample_i,
  output logic              conv_start_o,
  output logic              busy_o,
  output logic              os_ready_o,
  output logic              result_valid_o,
  output logic [TEMP_W-1:0] temp_o,
  output logic [1:0]        res_bits_o
);
  logic start_now_w, done_w, busy_w;

  os_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .shutdown_i   (shutdown_i),
    .wr_i         (cfg_wr_i),
    .wr_os_i      (cfg_os_i),
    .done_i       (done_w),
    .start_now_o  (start_now_w),
    .busy_o       (busy_w),
    .start_pulse_o(conv_start_o),
    .ready_o      (os_ready_o)
  );

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(start_now_w),
    .running_i(busy_w),
    .done_o   (done_w)
  );

  temp_result #(.TEMP_W(TEMP_W)) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done_w),
    .sample_i(temp_sample_i),
    .valid_o (result_valid_o),
    .temp_o  (temp_o)
  );

  assign busy_o     = busy_w;
  assign res_bits_o = RES_12BIT;
endmodule

// File: rtl/oneshot_conv_ctrl_chk.sv
module oneshot_conv_ctrl_chk #(
  parameter int TEMP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shutdown_i,
  input logic              cfg_wr_i,
  input logic              cfg_os_i,
  input logic [TEMP_W-1:0] temp_sample_i,
  input logic              conv_done,
  input logic              conv_start_o,
  input logic              busy_o,
  input logic              os_ready_o,
  input logic              result_valid_o,
  input logic [TEMP_W-1:0] temp_o
);
  assert_oneshot_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && shutdown_i && cfg_wr_i && cfg_os_i) |=> (conv_start_o && busy_o));

  assert_ready_low_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !os_ready_o);

  assert_return_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && shutdown_i) |=> (!busy_o && os_ready_o && !conv_start_o));

  assert_no_extra_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conv_done) |=> !conv_start_o);

  assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !shutdown_i) |=> (busy_o && conv_start_o));

  assert_result_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (result_valid_o && temp_o == $past(temp_sample_i)));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !result_valid_o);
endmodule

bind oneshot_conv_ctrl oneshot_conv_ctrl_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .shutdown_i    (shutdown_i),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_os_i      (cfg_os_i),
  .temp_sample_i (temp_sample_i),
  .conv_done     (done_w),
  .conv_start_o  (conv_start_o),
  .busy_o        (busy_o),
  .os_ready_o    (os_ready_o),
  .result_valid_o(result_valid_o),
  .temp_o        (temp_o)
);

// File: tb/oneshot_conv_ctrl_tb_top.sv
module oneshot_conv_ctrl_tb_top;
  localparam int C  = 8;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shutdown_i = 1'b1;
  logic          cfg_wr_i = 1'b0;
  logic          cfg_os_i = 1'b0;
  logic [TW-1:0] temp_sample_i = '0;
  logic          conv_start_o, busy_o, os_ready_o, result_valid_o;
  logic [TW-1:0] temp_o;
  logic [1:0]    res_bits_o;

  int errors = 0, checks = 0, start_cnt = 0, res_cnt = 0;
  bit finished = 0;
  logic [TW-1:0] exp_q[$];

  always #5 clk = ~clk;

  oneshot_conv_ctrl #(.CONV_CYCLES(C), .TEMP_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown_i), .cfg_wr_i(cfg_wr_i),
    .cfg_os_i(cfg_os_i), .temp_sample_i(temp_sample_i), .conv_start_o(conv_start_o),
    .busy_o(busy_o), .os_ready_o(os_ready_o), .result_valid_o(result_valid_o),
    .temp_o(temp_o), .res_bits_o(res_bits_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // Monitor: pops expected results as the design produces them (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start_o) start_cnt++;
      if (result_valid_o) begin
        res_cnt++;
        if (exp_q.size() == 0) chk("R7 unexpected result", 32'(temp_o), 32'hFFFF_FFFF);
        else chk("R7 result value", 32'(temp_o), 32'(exp_q.pop_front()));
      end
    end
  end

  // Driver: one-shot launch, expected result pushed to the scoreboard
  task automatic one_shot(input logic [TW-1:0] val, input bit poke_mid);
    int s0;
    s0 = start_cnt;
    temp_sample_i = val;
    exp_q.push_back(val);
    cfg_wr_i = 1; cfg_os_i = 1;
    step();                                 // after launch edge
    cfg_wr_i = 0; cfg_os_i = 0;
    chk("R2 start pulse", 32'(conv_start_o), 1);
    chk("R2 busy", 32'(busy_o), 1);
    chk("R3 ready low", 32'(os_ready_o), 0);
    for (int k = 1; k < C; k++) begin
      if (poke_mid && k == C/2) begin cfg_wr_i = 1; cfg_os_i = 1; end
      step();
      cfg_wr_i = 0; cfg_os_i = 0;
      chk("R2 busy held", 32'(busy_o), 1);
      chk("R3 ready low busy", 32'(os_ready_o), 0);
    end
    step();                                 // after completing edge
    chk("R4 idle", 32'(busy_o), 0);
    chk("R4 ready set", 32'(os_ready_o), 1);
    chk("R7 valid", 32'(result_valid_o), 1);
    step();
    chk("R7 valid one cycle", 32'(result_valid_o), 0);
    repeat (2*C) step();
    chk("R4 stays idle", 32'(busy_o), 0);
    chk("R4 ready held", 32'(os_ready_o), 1);
    chk("R5 single start", 32'(start_cnt - s0), 1);
  endtask

  initial begin
    int s0, r0;
    repeat (3) step();
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 start", 32'(conv_start_o), 0);
    chk("R1 ready", 32'(os_ready_o), 0);
    chk("R1 valid", 32'(result_valid_o), 0);
    chk("R1 temp", 32'(temp_o), 0);
    chk("R9 resolution", 32'(res_bits_o), 32'h3);
    rst_n = 1;
    repeat (3) step();
    chk("R1 idle after reset", 32'(busy_o), 0);

    one_shot(12'h123, 0);

    // R5: write of 0 in shutdown is ignored
    s0 = start_cnt;
    cfg_wr_i = 1; cfg_os_i = 0;
    step(); cfg_wr_i = 0;
    repeat (3) step();
    chk("R5 zero write ignored busy", 32'(busy_o), 0);
    chk("R5 zero write ignored starts", 32'(start_cnt - s0), 0);

    // R5: one-shot write during running conversion
    r0 = res_cnt;
    one_shot(12'h7F0, 1);
    chk("R5 one result", 32'(res_cnt - r0), 1);

    // R6: continuous mode, with an ignored one-shot write
    s0 = start_cnt; r0 = res_cnt;
    temp_sample_i = 12'hABC;
    repeat (4) exp_q.push_back(12'hABC);
    shutdown_i = 0;
    for (int k = 0; k < 3*C; k++) begin
      if (k == C + 2) begin cfg_wr_i = 1; cfg_os_i = 1; end
      step();
      cfg_wr_i = 0; cfg_os_i = 0;
      chk("R6 busy continuous", 32'(busy_o), 1);
    end
    chk("R6 start count", 32'(start_cnt - s0), 3);
    chk("R5 no extra start continuous", 32'(res_cnt - r0), 2);

    // R8: shutdown in first cycle of fourth conversion
    step();
    chk("R6 fourth start", 32'(conv_start_o), 1);
    shutdown_i = 1;
    repeat (C-1) step();
    chk("R8 still converting", 32'(busy_o), 1);
    step();
    chk("R8 idle after finish", 32'(busy_o), 0);
    chk("R8 result produced", 32'(result_valid_o), 1);
    chk("R8 ready set", 32'(os_ready_o), 1);
    repeat (2*C) step();
    chk("R8 no further start", 32'(start_cnt - s0), 4);
    chk("R8 result count", 32'(res_cnt - r0), 4);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 0);
    chk("R9 resolution held", 32'(res_bits_o), 32'h3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule